// File: doc/BRIEF.md
# Power-Fail Supervisor with Write Protection

This block sits between a host and a battery-backed static memory and decides what the memory may do as the external supply comes and goes. It takes two digitized supply flags and produces five controls. The first flag says the supply is above the write-protect trip point. The second says the supply is above the lower battery switchover level. From these the block gates the host's chip-enable and write-enable strobes, disables the memory's data outputs, drives a system reset, selects battery or external supply for the storage, and opens a one-time battery seal.

Both supply flags pass through a two-flop synchronizer. While the synchronized trip flag is low, the block does the following:
- It forces both memory strobes inactive.
- It disables the data outputs.
- It enables the reset pull-down.

When the supply returns, a counter runs from zero. Write protection is lifted after `WP_CYC` counts. The reset pull-down is released after `RST_CYC` counts, which defaults to 200 times `CYC_PER_MS`. A supply failure at any point clears the counter at once.

The battery seal is closed from the factory. It opens the first time the supply is seen above the trip point. After that it stays open through every supply loss and every system reset. Only the dedicated active-low factory-clear input closes it again.

Top module: `pwr_supervisor`

## Requirements
- R1: While the synchronized trip flag is low, `mem_ce_no` and `mem_we_no` are held at 1 and `out_dis_o` is 1, whatever `ce_ni` and `we_ni` do.
- R2: When `vtp_ok_i` falls, `rst_pd_o` is 1 after the second rising clock edge. This is the synchronizer latency.
- R3: After `vtp_ok_i` rises and stays high, `rst_pd_o` is 1 after rising edges 1 to RST_CYC+1. It becomes 0 after edge RST_CYC+2.
- R4: After `vtp_ok_i` rises, `out_dis_o` goes 0 after edge WP_CYC+2, which is earlier than the reset release. From then on `mem_ce_no` follows `ce_ni` and `mem_we_no` follows `we_ni`.
- R5: `bat_sel_o` (1 = battery, 0 = external supply) equals the inverse of `vsw_ok_i` delayed by two rising edges.
- R6: `bat_en_o` (1 = seal open) becomes 1 after the third rising edge following a rise of `vtp_ok_i`. It then stays 1 through supply loss and through `rst_ni` pulses.
- R7: `bat_en_o` is cleared only by `fact_clr_ni` low, asynchronously. It stays 0 while `vtp_ok_i` stays low.
- R8: A supply failure during the reset stretch takes priority. Reset reasserts per R2, and the next power-up restarts the full RST_CYC+2 count.
- R9: `rst_pd_o` is a pull-down enable (1 = reset line pulled low) and is the only reset output. While `rst_ni` is low, `rst_pd_o` and `out_dis_o` are 1 and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| fact_clr_ni | input | 1 | Active-low factory clear of the battery seal |
| vtp_ok_i | input | 1 | Supply above write-protect trip point |
| vsw_ok_i | input | 1 | Supply above battery switchover level |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| mem_ce_no | output | 1 | Gated memory chip enable, active low |
| mem_we_no | output | 1 | Gated memory write enable, active low |
| out_dis_o | output | 1 | Memory data output disable |
| rst_pd_o | output | 1 | Reset pull-down enable (1 = reset low) |
| bat_sel_o | output | 1 | Storage supply select, 1 = battery |
| bat_en_o | output | 1 | Battery seal open |

## Verification
The bench walks each power-up cycle by cycle and compares it with the edge counts above. A counter that is off by one would move the write-protect or reset release by one cycle. A design that released reset before lifting protection would show strobes still blocked after reset goes away. It sweeps every strobe combination in the blocked phase and in the running phase, so a design that leaks a host write during protection shows up. It drops the supply midway through a stretch and then checks that the next power-up runs the full count rather than resuming. It pulses both the system reset and the supply to confirm that only the factory clear closes the seal.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_PROT = 2'd1,
    PH_HOLD = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/pwr_stretch_timer.sv
module pwr_stretch_timer
  import pwr_sup_pkg::*;
#(
  parameter int RST_CYC = 200,
  parameter int WP_CYC  = 100
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vtp_i,
  output phase_e phase_o
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] CNT_WP  = CNT_W'(WP_CYC);

  logic [CNT_W-1:0] cnt_q;

  // supply loss wins over any count in progress
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!vtp_i)         cnt_q <= '0;
    else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (!vtp_i)                phase_o = PH_OFF;
    else if (cnt_q < CNT_WP)   phase_o = PH_PROT;
    else if (cnt_q < CNT_END)  phase_o = PH_HOLD;
    else                       phase_o = PH_RUN;
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END);

  a_r3_release_from_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_END && $past(cnt_q) != CNT_END) |-> $past(cnt_q) == CNT_END - 1'b1);

  a_r8_loss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vtp_i |=> cnt_q == '0);
endmodule

// File: rtl/pwr_seal_latch.sv
module pwr_seal_latch (
  input  logic clk_i,
  input  logic fact_clr_ni,
  input  logic vtp_i,
  output logic bat_en_o
);
  logic seal_q;

  // only the factory clear closes the seal
  always_ff @(posedge clk_i or negedge fact_clr_ni) begin
    if (!fact_clr_ni) seal_q <= 1'b0;
    else if (vtp_i)   seal_q <= 1'b1;
  end

  assign bat_en_o = seal_q;

  a_r6_seal_sticky: assert property (@(posedge clk_i) disable iff (!fact_clr_ni)
    seal_q |=> seal_q);

  a_r7_no_open_without_supply: assert property (@(posedge clk_i) disable iff (!fact_clr_ni)
    (!seal_q && !vtp_i) |=> !seal_q);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  parameter int RST_CYC    = 200 * CYC_PER_MS,
  parameter int WP_CYC     = 100 * CYC_PER_MS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fact_clr_ni,
  input  logic vtp_ok_i,
  input  logic vsw_ok_i,
  input  logic ce_ni,
  input  logic we_ni,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic out_dis_o,
  output logic rst_pd_o,
  output logic bat_sel_o,
  output logic bat_en_o
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flags_s;
  logic             vtp_s, vsw_s, wp;
  phase_e           phase;

  pwr_sync #(.W(NFLAG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vsw_ok_i, vtp_ok_i}),
    .q_o   (flags_s)
  );

  assign vtp_s = flags_s[0];
  assign vsw_s = flags_s[1];

  pwr_stretch_timer #(.RST_CYC(RST_CYC), .WP_CYC(WP_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vtp_i  (vtp_s),
    .phase_o(phase)
  );

  pwr_seal_latch u_seal (
    .clk_i      (clk_i),
    .fact_clr_ni(fact_clr_ni),
    .vtp_i      (vtp_s),
    .bat_en_o   (bat_en_o)
  );

  assign wp        = (phase == PH_OFF) || (phase == PH_PROT);
  assign mem_ce_no = wp ? 1'b1 : ce_ni;
  assign mem_we_no = wp ? 1'b1 : we_ni;
  assign out_dis_o = wp;
  assign rst_pd_o  = (phase != PH_RUN);
  assign bat_sel_o = !vsw_s;

  a_r1_blocked_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vtp_s |-> (mem_ce_no && mem_we_no && out_dis_o));

  a_r2_reset_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vtp_s) |-> rst_pd_o);

  a_r4_protect_ends_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_pd_o |-> !out_dis_o);

  a_r5_battery_below_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsw_s |-> bat_sel_o);
endmodule

// File: tb/tb_pwr_supervisor.sv
module tb_pwr_supervisor;
  localparam int CPM = 4;
  localparam int RST = 40;
  localparam int WP  = 20;

  logic clk = 0, rst_n = 0, fclr_n = 0, vtp = 0, vsw = 0, ce_n = 1, we_n = 1;
  logic mce_n, mwe_n, odis, rpd, bsel, ben;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_supervisor #(.CYC_PER_MS(CPM), .RST_CYC(RST), .WP_CYC(WP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fact_clr_ni(fclr_n), .vtp_ok_i(vtp), .vsw_ok_i(vsw),
    .ce_ni(ce_n), .we_ni(we_n), .mem_ce_no(mce_n), .mem_we_no(mwe_n),
    .out_dis_o(odis), .rst_pd_o(rpd), .bat_sel_o(bsel), .bat_en_o(ben));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // power-up walk with ce_n=we_n=0; k = edges since vtp rose
  task automatic power_up(input bit seal_new);
    ce_n = 0; we_n = 0; vtp = 1; vsw = 1;
    for (int k = 1; k <= RST + 4; k++) begin
      step();
      chk("R4 out_dis", odis, k < WP + 2);
      chk("R4 we gate", mwe_n, k < WP + 2);
      chk("R3 rst_pd", rpd, k < RST + 2);
      if (seal_new) chk("R6 seal open", ben, k >= 3);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk("R9 rst_pd", rpd, 1); chk("R9 out_dis", odis, 1);
    chk("R9 ce", mce_n, 1); chk("R9 we", mwe_n, 1); chk("R7 seal closed", ben, 0);
    rst_n = 1; fclr_n = 1;
    // R1 sweep with supply low
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; we_n = c[1];
      step();
      chk("R1 ce", mce_n, 1); chk("R1 we", mwe_n, 1); chk("R1 out_dis", odis, 1);
      chk("R7 seal stays closed", ben, 0);
    end
    power_up(1);
    // R4 pass-through sweep in run
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; we_n = c[1];
      #1;
      chk("R4 ce pass", mce_n, c[0]); chk("R4 we pass", mwe_n, c[1]);
      chk("R4 out_dis", odis, 0);
    end
    chk("R5 external", bsel, 0);
    // supply drop: R2 latency, R5 switchover
    vtp = 0; vsw = 0; ce_n = 0; we_n = 0;
    step();
    chk("R2 not yet", rpd, 0); chk("R5 not yet", bsel, 0);
    step();
    chk("R2 reset", rpd, 1); chk("R5 battery", bsel, 1);
    chk("R1 we blocked", mwe_n, 1); chk("R6 seal kept", ben, 1);
    // R1 sweep while blocked again
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; we_n = c[1];
      step();
      chk("R1 ce", mce_n, 1); chk("R1 we", mwe_n, 1);
    end
    // R8 failure mid stretch
    ce_n = 0; we_n = 0; vtp = 1; vsw = 1;
    steps(WP + 8);
    chk("R8 hold phase", rpd, 1); chk("R4 protect off", odis, 0);
    vtp = 0;
    step(); step();
    chk("R8 reset", rpd, 1); chk("R8 protect", odis, 1);
    steps(3);
    power_up(0);
    // R6 through rst_ni pulse
    rst_n = 0; #1;
    chk("R9 rst_pd in reset", rpd, 1);
    step(); rst_n = 1;
    chk("R6 seal after reset", ben, 1);
    // R7 factory clear, asynchronous
    vtp = 0; steps(3);
    #2; fclr_n = 0; #1;
    chk("R7 cleared async", ben, 0);
    step(); fclr_n = 1;
    steps(10);
    chk("R7 stays closed", ben, 0);
    power_up(1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule